// File: doc/BRIEF.md
# Exact Multiply-Overflow Checker

This unit decides, with no false alarms, whether the unsigned product of two operands of equal width fits in that width. It multiplies by repeated shift-and-add into an accumulator twice as wide as an operand. Before each add step it looks at the upper half of that accumulator. If any bit there is set, it stops at once and reports overflow. If the multiplier runs out of bits first, it reports that the product fits.

A request is a single-cycle start strobe with both operands on the same cycle. The unit raises busy while it works. It ends with a one-cycle done pulse and an overflow flag that stays valid until the next accepted request. The accumulator is also visible on an output port. When there is no overflow it holds the full product, and after an early stop it holds the partial sum that crossed the limit.

Top module: `mulovf_top`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, busy, done and the overflow flag are low and the product output is zero.
- R2: A start strobe sampled while idle is accepted, and busy is high from the next cycle onward.
- R3: At done, the overflow flag is 1 exactly when the true product of the two operands is at least 2^W. Here W is the operand width, 64 by default.
- R4: When the product fits, done rises W+1 cycles after the accepting edge, and the product output then equals the exact product.
- R5: When the product overflows, done rises k+1 cycles after the accepting edge. Here k is the smallest count of low multiplier bits whose partial product, operand A times the multiplier's low k bits, reaches 2^W.
- R6: Done is high for exactly one cycle, and busy is low whenever done is high.
- R7: The overflow flag and the product output keep their values while idle with no start. The flag is cleared when a new request is accepted.
- R8: A start strobe that arrives while busy is ignored. The running request finishes with its own result and its own latency.
- R9: The operand pair 0x2 and 0x4000000000000000 gives overflow 0 and product 0x8000000000000000, which the bound based on bit position alone would flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled only while idle |
| op_a_i | input | W | Multiplicand operand |
| op_b_i | input | W | Multiplier operand |
| busy_o | output | 1 | High while a request is being worked |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| ovf_o | output | 1 | Exact overflow result, held until the next accepted start |
| product_o | output | 2W | Accumulator: the full product, or the partial sum at an early stop |

## Verification
The bench builds the unit at its default width of 64 bits, so the operand pairs that matter can be driven directly. These are 2^32 times 2^32, which lands exactly on the limit, (2^32-1) times (2^32+1), which lands one below it, and all-ones operands. Its reference model finds the expected stop cycle by forming the partial products for each count of low multiplier bits in turn. Every busy and done value is then compared with that model on every clock, so any early stop that comes one cycle off is detected. A second strobe is injected in the middle of long runs to show that the first request's result and latency are unchanged.

// File: rtl/mulovf_pkg.sv
// Package: shared types for the multiply-overflow checker.
// Assumes: nothing beyond a two-state sequencer.
package mulovf_pkg;

    // Sequencer states: waiting for a request, or iterating.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mulovf_upper_nz.sv
// Module: mulovf_upper_nz
// Reports whether any bit of the accumulator's upper half is set. The
// reduction is split into fixed-size groups, and the group flags are then
// ORed together, so the depth grows with the log of the width.
// Assumes: W >= 1 and GRP >= 1. The operand is zero-padded to a whole
// number of groups.
module mulovf_upper_nz #(
    parameter int W   = 64,
    parameter int GRP = 8
) (
    input  logic [W-1:0] hi_i,
    output logic         nz_o
);
    localparam int NGRP  = (W + GRP - 1) / GRP;
    localparam int PAD_W = NGRP * GRP;

    logic [PAD_W-1:0] padded;
    logic [NGRP-1:0]  grp_nz;

    // Zero-extend the upper half to whole groups.
    always_comb begin
        padded         = '0;
        padded[W-1:0]  = hi_i;
    end

    // One OR reduction per group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_nz[g] = |padded[g*GRP +: GRP];
    end

    assign nz_o = |grp_nz;

endmodule

// File: rtl/mulovf_datapath.sv
// Module: mulovf_datapath
// Holds the shifted multiplicand (2W bits), the multiplier (W bits) and
// the running sum (2W bits). A load clears the sum and captures the
// operands. A step adds the multiplicand when the multiplier's low bit is
// set, then moves the multiplicand left and the multiplier right by one.
// Assumes: load and step are never high together. The controller stops
// before the multiplicand could shift out of 2W bits.
module mulovf_datapath #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] sum_o,
    output logic [W-1:0]   sum_hi_o
);
    localparam int ACC_W = 2 * W;

    logic [ACC_W-1:0] mcand_q;
    logic [W-1:0]     mplier_q;
    logic [ACC_W-1:0] sum_q;
    logic [ACC_W-1:0] sum_add;

    // Candidate sum for this step: add only when the low multiplier bit is set.
    always_comb begin
        sum_add = mplier_q[0] ? (sum_q + mcand_q) : sum_q;
    end

    // Operand capture on load; add and shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            sum_q    <= '0;
        end else if (load_i) begin
            mcand_q  <= {{W{1'b0}}, a_i};
            mplier_q <= b_i;
            sum_q    <= '0;
        end else if (step_i) begin
            sum_q    <= sum_add;
            mcand_q  <= {mcand_q[ACC_W-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[W-1:1]};
        end
    end

    assign sum_o    = sum_q;
    assign sum_hi_o = sum_q[ACC_W-1:W];

    // R4
    skip_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mplier_q[0] && !load_i) |=> $stable(sum_q));

    // R4
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (mplier_q == {1'b0, $past(mplier_q[W-1:1])}));

endmodule

// File: rtl/mulovf_ctrl.sv
// Module: mulovf_ctrl
// Sequencer and step counter. When idle, a start strobe loads the datapath.
// On each run cycle it first checks the upper-half flag and finishes with
// overflow if that flag is set. Otherwise it finishes clean once the count
// reaches W, or it issues one add/shift step.
// Assumes: upper_nz_i reflects the current accumulator with no delay.
module mulovf_ctrl
    import mulovf_pkg::*;
#(
    parameter int W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic upper_nz_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o,
    output logic ovf_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             ovf_q;
    logic             accept;
    logic             fin_ovf;
    logic             fin_clean;
    logic             running;

    // Decode the decision for this cycle from the state, the count and the flag.
    always_comb begin
        running   = (state_q == SEQ_RUN);
        accept    = !running && start_i;
        fin_ovf   = running && upper_nz_i;
        fin_clean = running && !upper_nz_i && (cnt_q == LAST);
        step_o    = running && !upper_nz_i && (cnt_q != LAST);
        load_o    = accept;
    end

    // Sequencer, step counter and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= SEQ_RUN;
                cnt_q   <= '0;
                ovf_q   <= 1'b0;
            end else if (fin_ovf) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
                ovf_q   <= 1'b1;
            end else if (fin_clean) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
                ovf_q   <= 1'b0;
            end else if (step_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o = running;
    assign done_o = done_q;
    assign ovf_o  = ovf_q;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i && !upper_nz_i && cnt_q != LAST)
        |=> (state_q == SEQ_RUN && cnt_q == $past(cnt_q) + 1'b1));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_i) |=> (running && cnt_q == '0));

endmodule

// File: rtl/mulovf_top.sv
// Module: mulovf_top
// Exact overflow check for an unsigned W x W multiply, done by iterative
// shift-and-add with an early stop as soon as the upper half of the
// accumulator goes nonzero.
// Assumes: one request at a time. Starts seen while busy are dropped.
module mulovf_top #(
    parameter int W   = 64,
    parameter int GRP = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   op_a_i,
    input  logic [W-1:0]   op_b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           ovf_o,
    output logic [2*W-1:0] product_o
);
    logic         load;
    logic         step;
    logic         upper_nz;
    logic [W-1:0] sum_hi;

    mulovf_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .upper_nz_i (upper_nz),
        .load_o     (load),
        .step_o     (step),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o)
    );

    mulovf_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .sum_o    (product_o),
        .sum_hi_o (sum_hi)
    );

    mulovf_upper_nz #(.W(W), .GRP(GRP)) u_nz (
        .hi_i (sum_hi),
        .nz_o (upper_nz)
    );

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (product_o[2*W-1:W] != '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> (product_o[2*W-1:W] == '0));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !done_o) |=> ($stable(ovf_o) && $stable(product_o)));

endmodule

// File: tb/mulovf_top_test.sv
// Bench for mulovf_top: a behavioural reference that uses full 128-bit
// products and partial products, compared against busy and done on every clock.
module mulovf_top_test;
    localparam int W = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [W-1:0]   op_a_i = '0;
    logic [W-1:0]   op_b_i = '0;
    logic           busy_o;
    logic           done_o;
    logic           ovf_o;
    logic [2*W-1:0] product_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    mulovf_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .product_o(product_o)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: expected check count is one more than the first k at which
    // a * (b's low k bits) reaches 2^W; it is W+1 if that never happens.
    function automatic int exp_checks(input logic [W-1:0] a, input logic [W-1:0] b);
        for (int k = 0; k <= W; k++) begin
            logic [W-1:0]   mb;
            logic [2*W-1:0] pp;
            mb = (k == W) ? b : (b & ((64'd1 << k) - 64'd1));
            pp = {{W{1'b0}}, a} * {{W{1'b0}}, mb};
            if (pp[2*W-1:W] != '0) return k + 1;
        end
        return W + 1;
    endfunction

    task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [2*W-1:0] full;
        bit   exp_ovf;
        int   n;
        int   exp_n;
        full    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        exp_ovf = (full[2*W-1:W] != '0);
        exp_n   = exp_checks(a, b);
        @(negedge clk);
        start_i = 1'b1; op_a_i = a; op_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        // R2: busy right after the accepting edge; R7: flag cleared on accept
        check("R2 busy after start", busy_o, 1);
        check("R7 ovf cleared on accept", ovf_o, 0);
        n = 0;
        forever begin
            if (poke && n == 3) begin
                start_i = 1'b1; op_a_i = ~a; op_b_i = ~b;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
            if (n < exp_n) begin
                // R5/R4: cycle-by-cycle comparison against the model
                check("R4/R5 busy during run", {busy_o, done_o}, 2'b10);
            end else begin
                break;
            end
        end
        start_i = 1'b0;
        // R6: done pulse with busy low at the expected cycle
        check(exp_ovf ? "R5 done at early stop cycle" : "R4 done at full length",
              {busy_o, done_o}, 2'b01);
        // R3: exact overflow result
        check(poke ? "R8 ovf of first request" : "R3 exact ovf", ovf_o, exp_ovf);
        if (!exp_ovf) check("R4 product", product_o, full);
        @(negedge clk);
        check("R6 done one cycle", done_o, 0);
        @(negedge clk);
        // R7: result holds while idle
        check("R7 ovf held", ovf_o, exp_ovf);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy_o, done_o, ovf_o}, 3'b000);
        check("R1 reset product", product_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {busy_o, done_o, ovf_o}, 3'b000);

        run_case(64'h0, 64'h0, 0);
        run_case(64'h1, 64'h10, 0);
        // R9: exact answer where a bit-position bound would flag overflow
        run_case(64'h2, 64'h4000000000000000, 0);
        check("R9 no overflow", ovf_o, 0);
        check("R9 product", product_o, 128'h8000000000000000);
        run_case(64'h3, 64'h7FFFFFFFFFFFFFFF, 0);
        run_case(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 0);
        run_case(64'hFFFFFFFFFFFFFFFF, 64'h1, 0);
        run_case(64'h100000000, 64'h100000000, 0);
        run_case(64'hFFFFFFFF, 64'h100000001, 0);
        run_case(64'h8000000000000000, 64'h2, 0);
        // R8: strobes in the middle of long runs are dropped
        run_case(64'h1, 64'hFFFFFFFFFFFFFFFF, 1);
        run_case(64'h0, 64'hFFFFFFFFFFFFFFFF, 1);
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = {$urandom, $urandom} >> ($urandom % 64);
            rb = {$urandom, $urandom} >> ($urandom % 64);
            run_case(ra, rb, (i % 4) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule